// File: doc/BRIEF.md
# Mixed-Access Control/Status Register Bank with Mailbox

This block is a small bank of memory-mapped 32-bit registers on a simple processor-side bus. The bus carries a byte address, read and write strobes, write data and a per-bit write mask. At every address the lower 16 bits belong to software: they are written through the mask and read back. The upper 16 bits belong to the device: they are loaded each clock from a hardware status input. A read returns both halves as one word, so software can read a register and write it at the same address.

Two registers form a mailbox. Software places a 16-bit word in the lower half of the data register. It then sets bit 0 of the control register as a ready flag. The consuming logic inside the device sees the word and the flag on dedicated outputs and pulses a take input. That clears the flag, which tells software that the word has been taken. The flag is the one bit that both sides can write. If both write it in the same cycle, the software set wins, so a freshly posted word cannot be lost.

Top module: `csr_mailbox_bank`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), the lower half of every register reads as 0 and `mbx_ready` is 0.
- R2: A write that hits register n updates bit k of its lower half (k in 0..15) only where `bus_wmask[k]` is 1. Bits whose mask is 0 keep their value.
- R3: Bits 31:16 of a write, in both data and mask, have no effect. The read value of bits 31:16 is set only by the hardware status input.
- R4: A read asserted at clock edge E drives `bus_rvalid` high for exactly the cycle after E, with `bus_rdata` holding that read's result. `bus_rvalid` is low in every cycle that does not follow a read.
- R5: Register n sits at byte address `BASE_ADDR + 4*n` for n in 0..7. Address bits 1:0 are ignored, and address bits 4:2 give n.
- R6: An address whose bits above bit 4 differ from those of `BASE_ADDR` is outside the bank. A read there returns 0 with `bus_rvalid` still pulsing, and a write there changes no register.
- R7: Bits 31:16 of register n read as `hw_status[16n+15:16n]` as that input stood one clock edge before the read edge. A status change applied in the same cycle as the read is not yet visible.
- R8: `mbx_data` always shows the lower half of register 6 (the mailbox data register). `mbx_ready` always shows bit 0 of register 7 (the mailbox control register). Software sets the flag by writing 1 to bit 0 of register 7 with mask bit 0 set.
- R9: When `mbx_take` is high at an edge while `mbx_ready` is 1, the flag reads 0 after that edge. When the flag is already 0, `mbx_take` changes nothing.
- R10: When `mbx_take` and a write setting bit 0 of register 7 fall on the same edge, the flag is 1 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_wmask | input | 32 | Per-bit write enable |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | One-cycle pulse marking read data |
| hw_status | input | 128 | Upper half source, 16 bits per register |
| mbx_take | input | 1 | Internal consumer takes the mailbox word |
| mbx_data | output | 16 | Mailbox data word |
| mbx_ready | output | 1 | Mailbox ready flag |

## Verification
Two actions can land on the mailbox flag in the same cycle: a software write that sets it and the internal take that clears it. The bench first posts a word and sets the flag. It then raises `mbx_take` on the same edge as a second write that sets bit 0 of the control register. The flag must still read 1 afterwards, and a later take on its own must clear it. A second same-cycle case is a status change applied together with a read, which must return the older status.

// File: rtl/csr_bank_pkg.sv
// Shared widths and types for the mixed-access register bank.
// Assumes a 32-bit register split into two equal 16-bit halves.
package csr_bank_pkg;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned HALF_W = REG_W / 2;
    typedef logic [HALF_W-1:0] half_t;
endpackage

// File: rtl/csr_bank_decode.sv
// Address decoder: checks that a byte address falls inside the bank and
// turns bits [IDX_W+1:2] into a word index and a one-hot write select.
// Assumes NUM_REGS is a power of two and BASE_ADDR is aligned to the bank span.
module csr_bank_decode #(
    parameter int unsigned NUM_REGS  = 8,
    parameter int unsigned ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0040,
    localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr,
    output logic                hit,
    output logic [IDX_W-1:0]    idx,
    output logic [NUM_REGS-1:0] wr_sel
);
    localparam int unsigned TAG_LO = IDX_W + 2;

    logic [1:0] unused_lsb;
    assign unused_lsb = addr[1:0];

    // compare the tag bits with the bank base and extract the word index
    always_comb begin
        hit = (addr[ADDR_W-1:TAG_LO] == BASE_ADDR[ADDR_W-1:TAG_LO]);
        idx = addr[TAG_LO-1:2];
    end

    // one select line per register, active only on an in-bank write
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign wr_sel[g] = wr && hit && (idx == IDX_W'(g));
    end
endmodule

// File: rtl/csr_rw_half.sv
// Software-owned lower half of one register. A selected write merges data
// through the mask. Bit 0 can also be cleared by hardware, and a software
// write to bit 0 in the same cycle overrides that clear.
module csr_rw_half
    import csr_bank_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_sel,
    input  half_t wdata,
    input  half_t wmask,
    input  logic  hw_clr,
    output half_t q
);
    half_t nxt;

    // hardware clear first, then the masked software merge on top of it
    always_comb begin
        nxt = q;
        if (hw_clr) nxt[0] = 1'b0;
        if (wr_sel) nxt = (nxt & ~wmask) | (wdata & wmask);
    end

    // state register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    // R2
    masked_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && !hw_clr) |=> ((q & ~$past(wmask)) == ($past(q) & ~$past(wmask))));
    // R10
    sw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && wmask[0] && wdata[0]) |=> q[0]);
    // R9
    hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_clr && !(wr_sel && wmask[0])) |=> !q[0]);
endmodule

// File: rtl/csr_read_port.sv
// Registered read path: selects the addressed register and joins its two
// halves. Out-of-bank reads give zero. Data and valid appear one cycle after
// the read strobe.
module csr_read_port
    import csr_bank_pkg::*;
#(
    parameter int unsigned NUM_REGS = 8,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd,
    input  logic                        hit,
    input  logic [IDX_W-1:0]            idx,
    input  half_t [NUM_REGS-1:0]        lower,
    input  half_t [NUM_REGS-1:0]        upper,
    output logic [REG_W-1:0]            rdata,
    output logic                        rvalid
);
    // capture the selected word and raise valid for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd;
            if (rd) rdata <= hit ? {upper[idx], lower[idx]} : '0;
        end
    end

    // R4
    rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rvalid);
    // R4
    rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !rvalid);
    // R6
    miss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !hit) |=> (rdata == '0));
endmodule

// File: rtl/csr_mailbox_bank.sv
// Top of the mixed-access register bank. Each register has a software lower
// half (csr_rw_half) and a hardware upper half sampled from hw_status every
// clock. Registers MBX_DATA_IDX and MBX_CTRL_IDX form the mailbox. The take
// input clears the ready flag (bit 0 of the control register).
module csr_mailbox_bank
    import csr_bank_pkg::*;
#(
    parameter int unsigned NUM_REGS      = 8,
    parameter int unsigned ADDR_W        = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0040,
    parameter int unsigned MBX_DATA_IDX  = 6,
    parameter int unsigned MBX_CTRL_IDX  = 7,
    localparam int unsigned IDX_W        = $clog2(NUM_REGS),
    localparam int unsigned STAT_W       = NUM_REGS * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic [REG_W-1:0]  bus_wmask,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              bus_rvalid,
    input  logic [STAT_W-1:0] hw_status,
    input  logic              mbx_take,
    output logic [HALF_W-1:0] mbx_data,
    output logic              mbx_ready
);
    logic                  hit;
    logic [IDX_W-1:0]      idx;
    logic [NUM_REGS-1:0]   wr_sel;
    half_t [NUM_REGS-1:0]  lower;
    half_t [NUM_REGS-1:0]  status_q;
    logic                  take_eff;
    logic [REG_W-1:HALF_W] unused_wdata_hi;
    logic [REG_W-1:HALF_W] unused_wmask_hi;

    assign unused_wdata_hi = bus_wdata[REG_W-1:HALF_W];
    assign unused_wmask_hi = bus_wmask[REG_W-1:HALF_W];

    csr_bank_decode #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR)
    ) i_decode (
        .addr  (bus_addr),
        .wr    (bus_wr),
        .hit   (hit),
        .idx   (idx),
        .wr_sel(wr_sel)
    );

    // a take only counts while the flag is set
    assign take_eff = mbx_take && mbx_ready;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        csr_rw_half i_half (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_sel(wr_sel[g]),
            .wdata (bus_wdata[HALF_W-1:0]),
            .wmask (bus_wmask[HALF_W-1:0]),
            .hw_clr((g == MBX_CTRL_IDX) ? take_eff : 1'b0),
            .q     (lower[g])
        );

        // sample this register's hardware-owned half every clock
        always_ff @(posedge clk) begin
            if (!rst_n) status_q[g] <= '0;
            else        status_q[g] <= hw_status[g*HALF_W +: HALF_W];
        end
    end

    csr_read_port #(
        .NUM_REGS(NUM_REGS)
    ) i_read (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (bus_rd),
        .hit   (hit),
        .idx   (idx),
        .lower (lower),
        .upper (status_q),
        .rdata (bus_rdata),
        .rvalid(bus_rvalid)
    );

    assign mbx_data  = lower[MBX_DATA_IDX];
    assign mbx_ready = lower[MBX_CTRL_IDX][0];

    // R3
    upper_from_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (|unused_wmask_hi) && (|unused_wdata_hi)) |=>
            (status_q == $past(hw_status)));
    // R6
    miss_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hit && !mbx_take) |=> $stable(lower));
    // R10
    flag_kept_on_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mbx_take && wr_sel[MBX_CTRL_IDX] && bus_wmask[0] && bus_wdata[0]) |=> mbx_ready);
endmodule

// File: tb/test_csr_mailbox_bank.sv
// Directed bench for csr_mailbox_bank: one task per scenario.
module test_csr_mailbox_bank;
    localparam logic [15:0] BASE = 16'h0040;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_wmask = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [127:0] hw_status = '0;
    logic        mbx_take = 1'b0;
    logic [15:0] mbx_data;
    logic        mbx_ready;

    int total = 0;
    int bad = 0;
    logic [31:0] rd_val;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    csr_mailbox_bank i_csr_mailbox_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_wmask(bus_wmask),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .hw_status(hw_status),
        .mbx_take(mbx_take), .mbx_data(mbx_data), .mbx_ready(mbx_ready)
    );

    function automatic logic [15:0] stat_of(int n);
        return hw_status[n*16 +: 16];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [15:0] a, logic [31:0] d, logic [31:0] m);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wmask = m; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [15:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R4 rvalid", {31'd0, bus_rvalid}, 32'd1);
        rd_val = bus_rdata;
    endtask

    task automatic t_reset();
        for (int n = 0; n < 8; n++) begin
            bus_read(BASE + 16'(4*n));
            chk("R1 reset lower", {16'd0, rd_val[15:0]}, 32'd0);
        end
        chk("R1 ready", {31'd0, mbx_ready}, 32'd0);
        bus_read(BASE + 16'd20);
        chk("R7 upper", {16'd0, rd_val[31:16]}, {16'd0, stat_of(5)});
    endtask

    task automatic t_mask();
        bus_write(BASE + 16'd4, 32'hFFFF_1234, 32'hFFFF_FFFF);
        bus_read(BASE + 16'd4);
        chk("R3 upper ignored", rd_val, {stat_of(1), 16'h1234});
        bus_write(BASE + 16'd4, 32'h0000_ABCD, 32'h0000_00F0);
        bus_read(BASE + 16'd4);
        chk("R2 masked write", rd_val, {stat_of(1), 16'h12C4});
    endtask

    task automatic t_decode();
        bus_write(BASE + 16'h000B, 32'h0000_5A5A, 32'h0000_FFFF);
        bus_read(BASE + 16'h0008);
        chk("R5 low bits ignored", {16'd0, rd_val[15:0]}, 32'h5A5A);
        bus_read(BASE + 16'h000E);
        chk("R5 neighbour untouched", {16'd0, rd_val[15:0]}, 32'd0);
    endtask

    task automatic t_outside();
        bus_write(16'h0060, 32'h0000_FFFF, 32'hFFFF_FFFF);
        bus_write(16'h0020, 32'h0000_FFFF, 32'hFFFF_FFFF);
        bus_read(16'h0060);
        chk("R6 miss reads zero", rd_val, 32'd0);
        bus_read(BASE);
        chk("R6 alias not written", {16'd0, rd_val[15:0]}, 32'd0);
    endtask

    task automatic t_latency();
        @(negedge clk);
        chk("R4 idle rvalid", {31'd0, bus_rvalid}, 32'd0);
        bus_read(BASE + 16'd4);
        chk("R4 data", rd_val, {stat_of(1), 16'h12C4});
        @(negedge clk);
        chk("R4 single pulse", {31'd0, bus_rvalid}, 32'd0);
    endtask

    task automatic t_status_timing();
        logic [15:0] old_s;
        old_s = stat_of(3);
        @(negedge clk);
        hw_status[3*16 +: 16] = 16'hC0DE;
        bus_addr = BASE + 16'd12; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R7 same-cycle change hidden", {16'd0, bus_rdata[31:16]}, {16'd0, old_s});
        bus_read(BASE + 16'd12);
        chk("R7 change visible", {16'd0, rd_val[31:16]}, 32'hC0DE);
    endtask

    task automatic t_mailbox();
        bus_write(BASE + 16'd24, 32'h0000_BEEF, 32'h0000_FFFF);
        chk("R8 data out", {16'd0, mbx_data}, 32'hBEEF);
        @(negedge clk); mbx_take = 1'b1;
        @(negedge clk); mbx_take = 1'b0;
        chk("R9 take when idle", {31'd0, mbx_ready}, 32'd0);
        chk("R9 data kept", {16'd0, mbx_data}, 32'hBEEF);
        bus_write(BASE + 16'd28, 32'h0000_0001, 32'h0000_0001);
        chk("R8 ready set", {31'd0, mbx_ready}, 32'd1);
        bus_read(BASE + 16'd28);
        chk("R8 ready readback", {31'd0, rd_val[0]}, 32'd1);
        @(negedge clk); mbx_take = 1'b1;
        @(negedge clk); mbx_take = 1'b0;
        chk("R9 take clears", {31'd0, mbx_ready}, 32'd0);
    endtask

    task automatic t_collision();
        bus_write(BASE + 16'd28, 32'h0000_0001, 32'h0000_0001);
        @(negedge clk);
        mbx_take = 1'b1;
        bus_addr = BASE + 16'd28; bus_wdata = 32'h1; bus_wmask = 32'h1; bus_wr = 1'b1;
        @(negedge clk);
        mbx_take = 1'b0; bus_wr = 1'b0;
        chk("R10 set wins", {31'd0, mbx_ready}, 32'd1);
        @(negedge clk); mbx_take = 1'b1;
        @(negedge clk); mbx_take = 1'b0;
        chk("R10 later take clears", {31'd0, mbx_ready}, 32'd0);
    endtask

    initial begin
        for (int n = 0; n < 8; n++) hw_status[n*16 +: 16] = 16'hA000 + 16'(n);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask();
        t_decode();
        t_outside();
        t_latency();
        t_status_timing();
        t_mailbox();
        t_collision();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule